// File: doc/BRIEF.md
# Multi-hart machine timer

This block is a memory-mapped timer shared by a group of harts. It keeps one free-running 64-bit time counter and, for each hart, a 64-bit compare value. Every hart has its own timer interrupt line, which is high for as long as that hart's compare value is no greater than the current time. The counter advances once on each bus clock cycle where a tick-enable input is high, so the timebase can run slower than the bus clock.

Software reaches every register through a 32-bit register port. Each 64-bit quantity is split into a low word at the lower address and a high word four bytes above it. Compare slots are laid out eight bytes apart from a configurable compare base. The time counter sits at a separate configurable time base and is read-only. Accesses that decode to no register are dropped without any side effect, and reads of them return zero.

Top module: `hart_timer`

## Requirements
- R1: After reset the time counter reads 0, every compare word reads 32'hFFFF_FFFF and every timer interrupt output is low.
- R2: The time counter increases by exactly one on each clock edge where tickEn is high and holds its value on every other edge.
- R3: A word read at TIME_BASE returns time bits 31:0 and a word read at TIME_BASE+4 returns bits 63:32. Writes to either address change nothing.
- R4: The compare value of hart k sits at CMP_BASE+8*k, with bits 31:0 at byte offset 0 and bits 63:32 at byte offset 4 of that slot, for k from 0 to NUM_HARTS-1.
- R5: A write to a compare low word replaces only bits 31:0 and keeps the stored bits 63:32. A write to a compare high word replaces only bits 63:32 and keeps bits 31:0.
- R6: timerIrq[k] is high exactly when the compare value of hart k is less than or equal to the time counter. It reacts on the first clock edge after a compare write or a tick, so a compare write into the past raises it at once.
- R7: A word-aligned address that is neither a compare word of a present hart nor a time word reads as zero, and a write to it changes no register.
- R8: An address whose bits 1:0 are not both zero reads as zero, and a write to it changes no register, even inside a register range.
- R9: rdData takes the value selected by a read request on the clock edge that samples the request, and holds it until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advances the time counter by one on this edge |
| acc | input | 1 | Register access request, one cycle per access |
| accWrite | input | 1 | High for a write access, low for a read |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, updated on the edge that samples a read |
| timerIrq | output | NUM_HARTS | Timer interrupt, one per hart |

## Verification
The bench builds the block with an 8-bit address, three harts, the compare base at 0x10 and the time base at 0x80. With these values the whole 256-byte address space can be read, and written with a marker, address by address. Every misaligned offset, every sub-slot and the slots past the last hart are checked against a model of the expected register contents. Interrupt behaviour is tested with short tick runs that bring compare values to equality, one step above, and into the past.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

  // Widest hart index the decode ever carries (up to 4095 harts).
  localparam int unsigned SLOT_W = 12;

  typedef enum logic [2:0] {
    RD_NONE    = 3'd0,
    RD_CMP_LO  = 3'd1,
    RD_CMP_HI  = 3'd2,
    RD_TIME_LO = 3'd3,
    RD_TIME_HI = 3'd4
  } rdSel_e;

  // Strobes passed from the address decode to the datapath.
  typedef struct packed {
    logic              rdStb;
    rdSel_e            rdSel;
    logic              wrLo;
    logic              wrHi;
    logic [SLOT_W-1:0] slot;
  } ctlStrobe_t;

endpackage

// File: rtl/hart_timer_decode.sv
module hart_timer_decode
  import hart_timer_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 16,
  parameter int unsigned     NUM_HARTS = 4,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acc,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        ctl
);

  localparam int unsigned CMP_SPAN = NUM_HARTS * 8;

  logic [ADDR_W-1:0] cmpOffset;
  logic              wordAligned;
  logic              inCmp;
  logic              isTimeLo;
  logic              isTimeHi;

  assign cmpOffset   = addr - CMP_BASE;
  assign wordAligned = (addr[1:0] == 2'b00);
  assign inCmp       = (addr >= CMP_BASE) && (32'(cmpOffset) < CMP_SPAN);
  assign isTimeLo    = (addr == TIME_BASE);
  assign isTimeHi    = (addr == TIME_BASE + ADDR_W'(4));

  always_comb begin
    ctl       = '0;
    ctl.rdSel = RD_NONE;
    ctl.slot  = SLOT_W'(cmpOffset >> 3);
    if (acc) begin
      ctl.rdStb = !accWrite;
      if (wordAligned && inCmp) begin
        if (accWrite) begin
          ctl.wrLo = !addr[2];
          ctl.wrHi = addr[2];
        end else begin
          ctl.rdSel = addr[2] ? RD_CMP_HI : RD_CMP_LO;
        end
      end else if (wordAligned && !accWrite && isTimeLo) begin
        ctl.rdSel = RD_TIME_LO;
      end else if (wordAligned && !accWrite && isTimeHi) begin
        ctl.rdSel = RD_TIME_HI;
      end
    end
  end

  // R8: misaligned accesses never reach a register
  p_misaligned_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (acc && addr[1:0] != 2'b00) |-> (!ctl.wrLo && !ctl.wrHi && ctl.rdSel == RD_NONE));

  // R3: time words take no write strobe
  p_time_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (acc && accWrite && (isTimeLo || isTimeHi)) |-> (!ctl.wrLo && !ctl.wrHi));

  // R5: at most one half of one slot is written per access
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrLo, ctl.wrHi, ctl.rdStb}));

endmodule

// File: rtl/hart_timer_core.sv
module hart_timer_core
  import hart_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  ctlStrobe_t           ctl,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic [NUM_HARTS-1:0] timerIrq
);

  logic [63:0] timeCnt;
  logic [63:0] cmpReg [NUM_HARTS];
  logic [63:0] cmpSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeCnt <= '0;
    end else if (tickEn) begin
      timeCnt <= timeCnt + 64'd1;
    end
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic hitSlot;
    assign hitSlot = (ctl.slot == SLOT_W'(h));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpReg[h] <= '1;
      end else if (hitSlot && ctl.wrLo) begin
        cmpReg[h] <= {cmpReg[h][63:32], wrData};
      end else if (hitSlot && ctl.wrHi) begin
        cmpReg[h] <= {wrData, cmpReg[h][31:0]};
      end
    end

    assign timerIrq[h] = (cmpReg[h] <= timeCnt);

    // R5: a low-word write keeps the high word
    p_keep_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
      (hitSlot && ctl.wrLo) |=> $stable(cmpReg[h][63:32]));

    // R5: a high-word write keeps the low word
    p_keep_lo_r5: assert property (@(posedge clk) disable iff (!rstN)
      (hitSlot && ctl.wrHi) |=> $stable(cmpReg[h][31:0]));
  end

  always_comb begin
    cmpSel = '0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (ctl.slot == SLOT_W'(h)) cmpSel = cmpReg[h];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.rdStb) begin
      unique case (ctl.rdSel)
        RD_CMP_LO:  rdData <= cmpSel[31:0];
        RD_CMP_HI:  rdData <= cmpSel[63:32];
        RD_TIME_LO: rdData <= timeCnt[31:0];
        RD_TIME_HI: rdData <= timeCnt[63:32];
        default:    rdData <= '0;
      endcase
    end
  end

  // R2: one step per enabled tick
  p_time_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (timeCnt == $past(timeCnt) + 64'd1));

  // R2: no step without a tick
  p_time_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timeCnt));

  // R6: with no write and no tick the interrupts cannot move
  p_irq_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.wrLo && !ctl.wrHi && !tickEn) |=> $stable(timerIrq));

  // R6: time moving forward can only raise interrupts
  p_irq_no_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.wrLo && !ctl.wrHi && tickEn) |=> (($past(timerIrq) & ~timerIrq) == '0));

  // R9: read data holds between reads
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdStb |=> $stable(rdData));

endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       NUM_HARTS = 4,
  parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'hBFF8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 acc,
  input  logic                 accWrite,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic [NUM_HARTS-1:0] timerIrq
);

  localparam longint unsigned CMP_END  = longint'(CMP_BASE) + longint'(NUM_HARTS) * 8;
  localparam longint unsigned TIME_END = longint'(TIME_BASE) + 8;

  if (NUM_HARTS < 1 || NUM_HARTS > 4095) begin : g_bad_harts
    $error("hart_timer: NUM_HARTS must lie in 1..4095");
  end
  if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
    $error("hart_timer: ADDR_W must lie in 4..32");
  end
  if (CMP_BASE[2:0] != 3'b000 || TIME_BASE[2:0] != 3'b000) begin : g_bad_align
    $error("hart_timer: both bases must be 8-byte aligned");
  end
  if (CMP_END > (64'd1 << ADDR_W) || TIME_END > (64'd1 << ADDR_W)) begin : g_bad_fit
    $error("hart_timer: register ranges exceed the address space");
  end
  if (!(longint'(TIME_BASE) >= CMP_END || TIME_END <= longint'(CMP_BASE))) begin : g_bad_overlap
    $error("hart_timer: time words overlap the compare slots");
  end

  ctlStrobe_t ctl;

  hart_timer_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_HARTS(NUM_HARTS),
    .CMP_BASE (CMP_BASE),
    .TIME_BASE(TIME_BASE)
  ) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .acc     (acc),
    .accWrite(accWrite),
    .addr    (addr),
    .ctl     (ctl)
  );

  hart_timer_core #(
    .NUM_HARTS(NUM_HARTS)
  ) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .ctl     (ctl),
    .wrData  (wrData),
    .rdData  (rdData),
    .timerIrq(timerIrq)
  );

endmodule

// File: tb/tb_hart_timer.sv
module tb_hart_timer;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NH = 3;
  localparam logic [AW-1:0] CB = 8'h10;
  localparam logic [AW-1:0] TB = 8'h80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic acc = 1'b0;
  logic accWrite = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NH-1:0] timerIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] expTime = '0;
  logic [63:0] expCmp [NH];

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_timer #(
    .ADDR_W(AW), .NUM_HARTS(NH), .CMP_BASE(CB), .TIME_BASE(TB)
  ) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .acc(acc), .accWrite(accWrite),
    .addr(addr), .wrData(wrData), .rdData(rdData), .timerIrq(timerIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isCmpWord(input int a);
    return (a[1:0] == 2'b00) && (a >= int'(CB)) && (a < int'(CB) + NH * 8);
  endfunction

  function automatic logic [31:0] expRead(input int a);
    int slot;
    if (a[1:0] != 2'b00) return 32'h0;
    if (isCmpWord(a)) begin
      slot = (a - int'(CB)) / 8;
      return a[2] ? expCmp[slot][63:32] : expCmp[slot][31:0];
    end
    if (a == int'(TB)) return expTime[31:0];
    if (a == int'(TB) + 4) return expTime[63:32];
    return 32'h0;
  endfunction

  function automatic string reqOf(input int a);
    if (a[1:0] != 2'b00) return "R8 misaligned";
    if (isCmpWord(a)) return "R4 compare slot";
    if (a == int'(TB) || a == int'(TB) + 4) return "R3 time word";
    return "R7 unmapped";
  endfunction

  function automatic logic [NH-1:0] expIrq();
    logic [NH-1:0] v;
    for (int h = 0; h < NH; h++) v[h] = (expCmp[h] <= expTime);
    return v;
  endfunction

  // Every task starts and ends at a falling edge.
  task automatic access(input bit w, input int a, input logic [31:0] d);
    acc = 1'b1; accWrite = w; addr = AW'(a); wrData = d;
    @(negedge clk);
    acc = 1'b0; accWrite = 1'b0;
  endtask

  task automatic wrReg(input int a, input logic [31:0] d);
    int slot;
    access(1'b1, a, d);
    if (isCmpWord(a)) begin
      slot = (a - int'(CB)) / 8;
      if (a[2]) expCmp[slot][63:32] = d;
      else      expCmp[slot][31:0]  = d;
    end
  endtask

  task automatic rdCheck(input string req, input int a);
    access(1'b0, a, 32'h0);
    check($sformatf("%s addr=%0h", req, a), rdData, expRead(a));
  endtask

  task automatic sweep();
    for (int a = 0; a < 256; a++) rdCheck(reqOf(a), a);
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
    expTime = expTime + 64'(n);
  endtask

  task automatic irqCheck(input string req);
    check(req, 32'(timerIrq), 32'(expIrq()));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    for (int h = 0; h < NH; h++) expCmp[h] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 irq after reset", 32'(timerIrq), 32'h0);
    rdCheck("R1 time low after reset", int'(TB));
    rdCheck("R1 compare high after reset", int'(CB) + 4);
    sweep();

    // R5: each half written alone keeps the other
    for (int h = 0; h < NH; h++) begin
      wrReg(int'(CB) + 8 * h, 32'h1111_0000 + h);
      rdCheck("R5 high kept after low write", int'(CB) + 8 * h + 4);
      wrReg(int'(CB) + 8 * h + 4, 32'h2222_0000 + h);
      rdCheck("R5 low kept after high write", int'(CB) + 8 * h);
    end
    sweep();

    // R3 R7 R8: writes everywhere outside the compare words change nothing
    for (int a = 0; a < 256; a++) begin
      if (!isCmpWord(a)) wrReg(a, 32'hDEAD_0000 | 32'(a));
    end
    sweep();
    irqCheck("R7 irq after dropped writes");

    // R2: continuous and gapped ticking
    ticks(37);
    rdCheck("R2 time after 37 ticks", int'(TB));
    for (int i = 0; i < 10; i++) begin
      ticks(1);
      @(negedge clk);
    end
    rdCheck("R2 time after gapped ticks", int'(TB));
    rdCheck("R2 time high word", int'(TB) + 4);

    // R6: equality, one above, and a write into the past
    wrReg(int'(CB) + 4, 32'h0);
    irqCheck("R6 hart0 high word cleared");
    wrReg(int'(CB), expTime[31:0]);
    irqCheck("R6 compare equal to time");
    wrReg(int'(CB) + 12, 32'h0);
    wrReg(int'(CB) + 8, expTime[31:0] + 32'd1);
    irqCheck("R6 compare one above time");
    wrReg(int'(CB) + 20, 32'h0);
    irqCheck("R6 hart2 still in future");
    wrReg(int'(CB) + 16, 32'd3);
    irqCheck("R6 compare written in the past");
    check("R6 irq pattern", 32'(timerIrq), 32'h5);
    ticks(1);
    irqCheck("R6 rise after one tick");
    check("R6 all raised", 32'(timerIrq), 32'h7);
    wrReg(int'(CB) + 4, 32'h1);
    irqCheck("R6 fall after raising compare");
    check("R6 hart0 lowered", 32'(timerIrq), 32'h6);

    // R9: read data holds across writes and idle cycles
    rdCheck("R9 read lands on sampling edge", int'(CB) + 8);
    held = rdData;
    wrReg(int'(CB) + 16, 32'h5555_AAAA);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    expTime = expTime + 64'd1;
    @(negedge clk);
    check("R9 hold between reads", rdData, held);
    rdCheck("R9 next read replaces value", int'(CB) + 16);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule